// File: doc/BRIEF.md
# DDR Command Decoder and Four-Bank State Tracker

This block watches the command pins of a DDR SDRAM interface. It can sit beside a memory controller as a protocol monitor, or inside a memory model as the front end. On every rising clock edge it samples the chip select, the row strobe, the column strobe, the write enable, the clock enable, the bank address and the address bit A10. It turns these into one command code, keeps a state machine for each bank, and checks the command against the state of the bank it addresses and against the state of all banks.

One cycle after the sampling edge, the block presents three things: the decoded command, the bank it addressed, and a single-cycle illegal flag. The current state of every bank is visible at all times. Transitional states last for a set number of cycles, which come from configuration inputs: activation delay, precharge time, refresh time, mode-set time and burst length in clock cycles. When a configuration value is zero, the block uses one cycle instead. A command at the edge where a bank's count runs out is judged against the state the bank is entering. An illegal command changes no bank, but bank timers keep running.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: With chip select low, {row strobe, column strobe, write enable} decodes as follows. 011 is activate (code 2). 101 is read (code 3, or 4 with A10 high). 100 is write (code 5, or 6 with A10 high). 010 is precharge (code 7, or precharge-all code 8 with A10 high). 001 with clock enable high is refresh (code 9). 000 is mode set (code 10). 110 is burst stop (code 11). 111 is no-operation (code 0). The command appears on `cmd_o` one cycle after the sampling edge.
- R2: Chip select high decodes as deselect (code 1), whatever the other strobes are. Deselect is never illegal and changes no bank.
- R3: Precharge moves an addressed bank in open, reading or writing state to closing. On an idle or closing bank, precharge is a legal no-op. Precharge-all does the same to every bank, and it is illegal if any bank is in a state where a single precharge would be illegal.
- R4: Activate is legal only on an idle bank (state 0). It moves the bank to opening (1). The bank becomes open (2) after `cfg_trcd` cycles. A read or write sampled earlier than that is illegal.
- R5: A read or write is legal only when the bank is open (2), reading (3) or writing (4). The bank then moves to reading or writing for `cfg_burst` cycles and afterwards returns to open.
- R6: Refresh and mode set are legal only when every bank is idle. They hold all banks in refreshing (8) for `cfg_trfc` cycles, or in mode-setting (9) for `cfg_tmrd` cycles, and then return every bank to idle.
- R7: Burst stop is legal only on a bank that is reading without auto-precharge. It returns that bank to open.
- R8: A read or write with auto-precharge holds the bank in state 5 (read) or 6 (write) for `cfg_burst` cycles. The bank then stays closing (7) for `cfg_trp` cycles before it is idle. Activate before then is illegal.
- R9: While a bank is in an auto-precharge state, any read, write, precharge or burst stop addressed to it is illegal.
- R10: `illegal_o` is a one-cycle pulse aligned with the offending command on `cmd_o`. An illegal command changes no bank state.
- R11: Strobes 001 sampled with clock enable low decode as unsupported (code 12) and are always illegal.
- R12: After synchronous reset, `cmd_o` is 0, `illegal_o` is 0 and every bank is idle.
- R13: A bank that is closing (7) becomes idle after `cfg_trp` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| cfg_trcd | input | CNT_W | Activate-to-open delay in cycles |
| cfg_trp | input | CNT_W | Precharge time in cycles |
| cfg_trfc | input | CNT_W | Refresh time in cycles |
| cfg_tmrd | input | CNT_W | Mode-set time in cycles |
| cfg_burst | input | CNT_W | Burst duration in cycles |
| cmd_o | output | 4 | Decoded command code |
| cmd_bank_o | output | BA_W | Bank address of the decoded command |
| illegal_o | output | 1 | One-cycle illegal-command pulse |
| bank_state_o | output | 4*2**BA_W | Four-bit state of each bank, bank 0 in the low bits |

## Verification
The bench builds the block with its default parameters: two bank-address bits (four banks) and eight-bit counters. It drives the timing inputs with small values. In the first phase these are 3/2/4/2 cycles with a two-cycle burst; after a second reset they are 5/4/6/3 with a four-cycle burst. These short windows mean that random traffic often lands a command on the same edge where a timer expires. They also mean refresh and mode set find all banks idle often enough to be legal. Directed sequences hit the exact cycle at which activation, auto-precharge closure and refresh complete, one cycle early and on time.

// File: rtl/ddr_trk_pkg.sv
// Package: shared codes for the DDR command tracker.
// Assumes a 4-bit command code and a 4-bit bank state; both are visible at ports.
package ddr_trk_pkg;

    localparam int ST_W  = 4;
    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP   = 4'd0,
        CMD_DESEL = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_RDA   = 4'd4,
        CMD_WR    = 4'd5,
        CMD_WRA   = 4'd6,
        CMD_PRE   = 4'd7,
        CMD_PREA  = 4'd8,
        CMD_REF   = 4'd9,
        CMD_MRS   = 4'd10,
        CMD_TERM  = 4'd11,
        CMD_UNSUP = 4'd12
    } cmd_e;

    typedef enum logic [ST_W-1:0] {
        BK_IDLE    = 4'd0,
        BK_OPENING = 4'd1,
        BK_OPEN    = 4'd2,
        BK_RD      = 4'd3,
        BK_WR      = 4'd4,
        BK_RDA     = 4'd5,
        BK_WRA     = 4'd6,
        BK_CLOSING = 4'd7,
        BK_REFRESH = 4'd8,
        BK_MODESET = 4'd9
    } bank_e;

    typedef enum logic [3:0] {
        ACT_NONE  = 4'd0,
        ACT_OPEN  = 4'd1,
        ACT_RD    = 4'd2,
        ACT_RDA   = 4'd3,
        ACT_WR    = 4'd4,
        ACT_WRA   = 4'd5,
        ACT_CLOSE = 4'd6,
        ACT_TERM  = 4'd7,
        ACT_REF   = 4'd8,
        ACT_MRS   = 4'd9
    } act_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
// Module: ddr_cmd_decode
// Turns the sampled command strobes into one command code.
// Assumes active-low strobes; clock enable only matters for the refresh pattern.
module ddr_cmd_decode
    import ddr_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic a10,
    output cmd_e cmd
);

    // Pure strobe-pattern decode.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
                3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
                3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b001:  cmd = cke ? CMD_REF : CMD_UNSUP;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_TERM;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_cmd_check.sv
// Module: ddr_cmd_check
// Judges a decoded command against the effective bank states and emits
// one action per bank; an illegal command yields no action anywhere.
// Assumes eff_st already reflects timers that expire on this edge.
module ddr_cmd_check
    import ddr_trk_pkg::*;
#(
    parameter int BA_W = 2,
    localparam int NB  = 1 << BA_W
) (
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   bank,
    input  bank_e [NB-1:0]    eff_st,
    output logic              illegal,
    output act_e  [NB-1:0]    act
);

    logic  all_idle;
    logic  prea_bad;
    bank_e sel_st;

    // Summaries over all banks used by refresh, mode set and precharge-all.
    always_comb begin
        all_idle = 1'b1;
        prea_bad = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (eff_st[i] != BK_IDLE) all_idle = 1'b0;
            if (!(eff_st[i] inside {BK_IDLE, BK_CLOSING, BK_OPEN, BK_RD, BK_WR}))
                prea_bad = 1'b1;
        end
        sel_st = eff_st[bank];
    end

    // Legality rules and per-bank action selection.
    always_comb begin
        illegal = 1'b0;
        for (int i = 0; i < NB; i++) act[i] = ACT_NONE;
        unique case (cmd)
            CMD_ACT: begin
                if (sel_st == BK_IDLE) act[bank] = ACT_OPEN;
                else                   illegal = 1'b1;
            end
            CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                if (sel_st inside {BK_OPEN, BK_RD, BK_WR}) begin
                    unique case (cmd)
                        CMD_RD:  act[bank] = ACT_RD;
                        CMD_RDA: act[bank] = ACT_RDA;
                        CMD_WR:  act[bank] = ACT_WR;
                        default: act[bank] = ACT_WRA;
                    endcase
                end else begin
                    illegal = 1'b1;
                end
            end
            CMD_PRE: begin
                if (sel_st inside {BK_OPEN, BK_RD, BK_WR}) act[bank] = ACT_CLOSE;
                else if (!(sel_st inside {BK_IDLE, BK_CLOSING})) illegal = 1'b1;
            end
            CMD_PREA: begin
                if (prea_bad) begin
                    illegal = 1'b1;
                end else begin
                    for (int i = 0; i < NB; i++)
                        if (eff_st[i] inside {BK_OPEN, BK_RD, BK_WR}) act[i] = ACT_CLOSE;
                end
            end
            CMD_REF, CMD_MRS: begin
                if (all_idle) begin
                    for (int i = 0; i < NB; i++)
                        act[i] = (cmd == CMD_REF) ? ACT_REF : ACT_MRS;
                end else begin
                    illegal = 1'b1;
                end
            end
            CMD_TERM: begin
                if (sel_st == BK_RD) act[bank] = ACT_TERM;
                else                 illegal = 1'b1;
            end
            CMD_UNSUP: illegal = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_bank_fsm.sv
// Module: ddr_bank_fsm
// State machine and down-counter for one bank. Timed states last
// max(N,1) cycles; eff_st shows the state after this edge's expiry,
// before any command action is applied.
// Assumes the action input is already legal for eff_st.
module ddr_bank_fsm
    import ddr_trk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  act_e             act,
    input  logic [CNT_W-1:0] cfg_trcd,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic [CNT_W-1:0] cfg_trfc,
    input  logic [CNT_W-1:0] cfg_tmrd,
    input  logic [CNT_W-1:0] cfg_burst,
    output bank_e            st,
    output bank_e            eff_st
);

    bank_e            st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, eff_cnt;

    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    // Timer expiry: where the bank stands at this edge without a command.
    always_comb begin
        eff_st  = st_q;
        eff_cnt = cnt_q;
        if (st_q != BK_IDLE && st_q != BK_OPEN) begin
            if (cnt_q == '0) begin
                unique case (st_q)
                    BK_OPENING, BK_RD, BK_WR: begin
                        eff_st = BK_OPEN;
                    end
                    BK_RDA, BK_WRA: begin
                        eff_st  = BK_CLOSING;
                        eff_cnt = load_of(cfg_trp);
                    end
                    default: eff_st = BK_IDLE;
                endcase
            end else begin
                eff_cnt = cnt_q - 1'b1;
            end
        end
    end

    // Command action applied on top of the effective state.
    always_comb begin
        st_d  = eff_st;
        cnt_d = eff_cnt;
        unique case (act)
            ACT_OPEN:  begin st_d = BK_OPENING; cnt_d = load_of(cfg_trcd);  end
            ACT_RD:    begin st_d = BK_RD;      cnt_d = load_of(cfg_burst); end
            ACT_RDA:   begin st_d = BK_RDA;     cnt_d = load_of(cfg_burst); end
            ACT_WR:    begin st_d = BK_WR;      cnt_d = load_of(cfg_burst); end
            ACT_WRA:   begin st_d = BK_WRA;     cnt_d = load_of(cfg_burst); end
            ACT_CLOSE: begin st_d = BK_CLOSING; cnt_d = load_of(cfg_trp);   end
            ACT_TERM:  begin st_d = BK_OPEN;    cnt_d = '0;                 end
            ACT_REF:   begin st_d = BK_REFRESH; cnt_d = load_of(cfg_trfc);  end
            ACT_MRS:   begin st_d = BK_MODESET; cnt_d = load_of(cfg_tmrd);  end
            default: ;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign st = st_q;

    // R4
    no_open_on_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {BK_OPEN, BK_RD, BK_WR}) |=> (st_q != BK_OPENING));

    // R8
    rda_to_closing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_RDA) |=> (st_q == BK_RDA || st_q == BK_CLOSING));

endmodule

// File: rtl/ddr_cmd_tracker.sv
// Module: ddr_cmd_tracker (top)
// Decodes the DDR command pins each rising edge, checks legality against
// the per-bank state machines, and registers command, bank and illegal flag.
// Assumes synchronous active-low reset and timing inputs held steady.
module ddr_cmd_tracker
    import ddr_trk_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int CNT_W = 8,
    localparam int NB   = 1 << BA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                cke,
    input  logic [BA_W-1:0]     ba,
    input  logic                a10,
    input  logic [CNT_W-1:0]    cfg_trcd,
    input  logic [CNT_W-1:0]    cfg_trp,
    input  logic [CNT_W-1:0]    cfg_trfc,
    input  logic [CNT_W-1:0]    cfg_tmrd,
    input  logic [CNT_W-1:0]    cfg_burst,
    output logic [CMD_W-1:0]    cmd_o,
    output logic [BA_W-1:0]     cmd_bank_o,
    output logic                illegal_o,
    output logic [NB*ST_W-1:0]  bank_state_o
);

    cmd_e            cmd_now, cmd_q;
    logic            ill_now, ill_q;
    logic [BA_W-1:0] bank_q;
    bank_e [NB-1:0]  eff_st;
    bank_e [NB-1:0]  cur_st;
    act_e  [NB-1:0]  act;

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .a10   (a10),
        .cmd   (cmd_now)
    );

    ddr_cmd_check #(.BA_W(BA_W)) u_chk (
        .cmd     (cmd_now),
        .bank    (ba),
        .eff_st  (eff_st),
        .illegal (ill_now),
        .act     (act)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        ddr_bank_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .act       (act[g]),
            .cfg_trcd  (cfg_trcd),
            .cfg_trp   (cfg_trp),
            .cfg_trfc  (cfg_trfc),
            .cfg_tmrd  (cfg_tmrd),
            .cfg_burst (cfg_burst),
            .st        (cur_st[g]),
            .eff_st    (eff_st[g])
        );
        assign bank_state_o[g*ST_W +: ST_W] = cur_st[g];

        // R6
        refresh_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_q == CMD_REF && !ill_q) |-> (cur_st[g] == BK_REFRESH));
    end

    // Output register for the decoded command report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            ill_q  <= 1'b0;
        end else begin
            cmd_q  <= cmd_now;
            bank_q <= ba;
            ill_q  <= ill_now;
        end
    end

    assign cmd_o      = cmd_q;
    assign cmd_bank_o = bank_q;
    assign illegal_o  = ill_q;

    // R2
    desel_never_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_DESEL) |-> !ill_q);

    // R10
    illegal_needs_command_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ill_q |-> (cmd_q != CMD_NOP && cmd_q != CMD_DESEL));

    // R11
    unsup_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_UNSUP) |-> ill_q);

endmodule

// File: tb/tb_ddr_cmd_tracker.sv
// Bench for ddr_cmd_tracker: fixed-seed random commands plus directed
// corner cases, compared every cycle against a behavioural bank model.
module tb_ddr_cmd_tracker;

    localparam int NB = 4;
    // Command codes (R1, R2, R11) and bank states (R4..R9, R13).
    localparam int C_NOP = 0, C_DES = 1, C_ACT = 2, C_RD = 3, C_RDA = 4, C_WR = 5,
                   C_WRA = 6, C_PRE = 7, C_PREA = 8, C_REF = 9, C_MRS = 10,
                   C_TERM = 11, C_UNS = 12;
    localparam int S_IDLE = 0, S_OPENING = 1, S_OPEN = 2, S_RD = 3, S_WR = 4,
                   S_RDA = 5, S_WRA = 6, S_CLOSING = 7, S_REF = 8, S_MOD = 9;

    logic clk = 0, rst_n = 0;
    logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, cke = 1, a10 = 0;
    logic [1:0] ba = 0;
    logic [7:0] trcd = 3, trp = 2, trfc = 4, tmrd = 2, tburst = 2;
    logic [3:0] cmd_o;
    logic [1:0] cmd_bank_o;
    logic       illegal_o;
    logic [15:0] bank_state_o;

    int n_chk = 0, n_fail = 0;
    int ms [NB];
    int mr [NB];
    int exp_cmd = 0, exp_ill = 0;
    bit armed = 0;

    always #2 clk = ~clk;

    ddr_cmd_tracker dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
        .cfg_trcd(trcd), .cfg_trp(trp), .cfg_trfc(trfc), .cfg_tmrd(tmrd),
        .cfg_burst(tburst), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
        .illegal_o(illegal_o), .bank_state_o(bank_state_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int len(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic string tag_of(input int c, input int ill);
        if (ill != 0 && c != C_UNS) return "R10";
        case (c)
            C_DES: return "R2";
            C_ACT: return "R4";
            C_RD, C_WR: return "R5";
            C_RDA, C_WRA: return "R8";
            C_PRE, C_PREA: return "R3";
            C_REF, C_MRS: return "R6";
            C_TERM: return "R7";
            C_UNS: return "R11";
            default: return "R13";
        endcase
    endfunction

    function automatic bit openish(input int s);
        return s == S_OPEN || s == S_RD || s == S_WR;
    endfunction

    // Advance the model by one sampling edge with the given pins.
    task automatic model_step(input logic cs, ras, cas, we, ck, input int b, input logic ap);
        int c;
        int ill;
        bit all_idle;
        bit bad;
        for (int i = 0; i < NB; i++) begin
            if (ms[i] != S_IDLE && ms[i] != S_OPEN) begin
                mr[i]--;
                if (mr[i] <= 0) begin
                    if (ms[i] == S_OPENING || ms[i] == S_RD || ms[i] == S_WR) ms[i] = S_OPEN;
                    else if (ms[i] == S_RDA || ms[i] == S_WRA) begin ms[i] = S_CLOSING; mr[i] = len(trp); end
                    else ms[i] = S_IDLE;
                end
            end
        end
        if (cs) c = C_DES;
        else case ({ras, cas, we})
            3'b011: c = C_ACT;
            3'b101: c = ap ? C_RDA : C_RD;
            3'b100: c = ap ? C_WRA : C_WR;
            3'b010: c = ap ? C_PREA : C_PRE;
            3'b001: c = ck ? C_REF : C_UNS;
            3'b000: c = C_MRS;
            3'b110: c = C_TERM;
            default: c = C_NOP;
        endcase
        all_idle = 1; bad = 0;
        for (int i = 0; i < NB; i++) begin
            if (ms[i] != S_IDLE) all_idle = 0;
            if (!(openish(ms[i]) || ms[i] == S_IDLE || ms[i] == S_CLOSING)) bad = 1;
        end
        ill = 0;
        case (c)
            C_ACT: if (ms[b] == S_IDLE) begin ms[b] = S_OPENING; mr[b] = len(trcd); end else ill = 1;
            C_RD, C_RDA, C_WR, C_WRA:
                if (openish(ms[b])) begin
                    ms[b] = (c == C_RD) ? S_RD : (c == C_RDA) ? S_RDA : (c == C_WR) ? S_WR : S_WRA;
                    mr[b] = len(tburst);
                end else ill = 1;
            C_PRE:
                if (openish(ms[b])) begin ms[b] = S_CLOSING; mr[b] = len(trp); end
                else if (ms[b] != S_IDLE && ms[b] != S_CLOSING) ill = 1;
            C_PREA:
                if (bad) ill = 1;
                else for (int i = 0; i < NB; i++)
                    if (openish(ms[i])) begin ms[i] = S_CLOSING; mr[i] = len(trp); end
            C_REF, C_MRS:
                if (all_idle) for (int i = 0; i < NB; i++) begin
                    ms[i] = (c == C_REF) ? S_REF : S_MOD;
                    mr[i] = (c == C_REF) ? len(trfc) : len(tmrd);
                end else ill = 1;
            C_TERM: if (ms[b] == S_RD) ms[b] = S_OPEN; else ill = 1;
            C_UNS: ill = 1;
            default: ;
        endcase
        exp_cmd = c;
        exp_ill = ill;
    endtask

    task automatic compare();
        string t;
        t = tag_of(exp_cmd, exp_ill);
        check("R1", "cmd_o", int'(cmd_o), exp_cmd);
        check(t, "illegal_o", int'(illegal_o), exp_ill);
        for (int i = 0; i < NB; i++)
            check(exp_ill != 0 ? "R9" : t, $sformatf("bank%0d state", i),
                  int'(bank_state_o[i*4 +: 4]), ms[i]);
    endtask

    // One cycle: check the previous result, then drive and model the next command.
    task automatic issue(input logic cs, ras, cas, we, ck, input int b, input logic ap);
        @(negedge clk);
        if (armed) compare();
        model_step(cs, ras, cas, we, ck, b, ap);
        cs_n = cs; ras_n = ras; cas_n = cas; we_n = we; cke = ck; ba = 2'(b); a10 = ap;
        armed = 1;
    endtask

    task automatic nop(input int n);
        for (int k = 0; k < n; k++) issue(0, 1, 1, 1, 1, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        if (armed) compare();
        armed = 0;
        rst_n = 0; cs_n = 1; cke = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NB; i++) begin ms[i] = S_IDLE; mr[i] = 0; end
        // R12: reset state
        check("R12", "cmd_o after reset", int'(cmd_o), C_NOP);
        check("R12", "illegal_o after reset", int'(illegal_o), 0);
        check("R12", "banks after reset", int'(bank_state_o), 0);
    endtask

    task automatic random_run(input int n);
        for (int k = 0; k < n; k++) begin
            int r;
            logic [2:0] s;
            r = $urandom % 100;
            s = 3'($urandom);
            if (r < 25)      issue(0, 1, 1, 1, 1, 0, 0);
            else if (r < 30) issue(1, s[2], s[1], s[0], 1, $urandom % 4, 1'($urandom));
            else if (r < 33) issue(0, 0, 0, 1, 0, $urandom % 4, 0);
            else begin
                int b;
                logic ap;
                b = $urandom % 4;
                ap = ($urandom % 4) == 0;
                if (r < 50)      issue(0, 0, 1, 1, 1, b, ap);
                else if (r < 62) issue(0, 1, 0, 1, 1, b, ap);
                else if (r < 72) issue(0, 1, 0, 0, 1, b, ap);
                else if (r < 82) issue(0, 0, 1, 0, 1, b, ap);
                else if (r < 88) issue(0, 1, 1, 0, 1, b, ap);
                else if (r < 94) issue(0, 0, 0, 1, 1, b, ap);
                else             issue(0, 0, 0, 0, 1, b, ap);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R4: read one cycle before tRCD is illegal, on time is legal.
        issue(0, 0, 1, 1, 1, 1, 0);
        nop(1);
        issue(0, 1, 0, 1, 1, 1, 0);
        issue(0, 1, 0, 1, 1, 1, 0);
        // R7: burst stop during a plain read returns the bank to open.
        issue(0, 1, 1, 0, 1, 1, 0);
        // R8, R9: read with auto-precharge, then stop/precharge/activate too early.
        issue(0, 1, 0, 1, 1, 1, 1);
        issue(0, 1, 1, 0, 1, 1, 0);
        issue(0, 0, 1, 0, 1, 1, 0);
        for (int k = 0; k < 5; k++) issue(0, 0, 1, 1, 1, 1, 0);
        // R6: refresh with a bank busy is illegal; precharge-all then refresh.
        issue(0, 0, 0, 1, 1, 0, 0);
        issue(0, 0, 1, 0, 1, 0, 1);
        nop(2);
        issue(0, 0, 0, 1, 1, 0, 0);
        issue(0, 0, 0, 0, 1, 0, 0);
        nop(3);
        issue(0, 0, 0, 0, 1, 0, 0);
        nop(2);
        // R11 and R2: clock-enable-low refresh pattern, deselect with activate strobes.
        issue(0, 0, 0, 1, 0, 2, 0);
        issue(1, 0, 1, 1, 1, 2, 0);
        // R13, R3: write, precharge, closing to idle, single precharge on idle bank.
        issue(0, 0, 1, 1, 1, 3, 0);
        nop(2);
        issue(0, 1, 0, 0, 1, 3, 0);
        issue(0, 0, 1, 0, 1, 3, 0);
        issue(0, 0, 1, 0, 1, 2, 0);
        nop(3);
        random_run(4000);
        trcd = 5; trp = 4; trfc = 6; tmrd = 3; tburst = 4;
        do_reset();
        // R8 with a longer burst: write with auto-precharge then activate each cycle.
        issue(0, 0, 1, 1, 1, 0, 0);
        nop(4);
        issue(0, 1, 0, 0, 1, 0, 1);
        for (int k = 0; k < 9; k++) issue(0, 0, 1, 1, 1, 0, 0);
        random_run(4000);
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule